// File: doc/BRIEF.md
# Phase-Snapped Read Window Generator

This block sits between a floppy drive's raw read pulse line and a floppy controller. It gives the controller a read window: a square wave whose half-cycles each hold at most one flux pulse, which the controller uses to tell clock bits from data bits. The timing source is not a tunable oscillator. A token circulates around a ring of discrete phases, clocked at a constant multiple of the bit cell rate. Each time a pulse arrives, the ring is forced to a fixed phase, so the pulse lands in the centre of the current half-window. A toggle flop after the ring makes the window, so forcing the ring never produces a runt or a glitch on the window. The loop has no filter and no frequency correction.

The raw pulse goes through a synchronizer and an edge detector. A copy of the pulse is then given out with a fixed latency, so that it lines up with the centre of a window half-cycle. The controller's sync input holds the ring cleared, the window low and the data output quiet until the controller expects valid data.

All pins are plain. There is no valid/ready stream. The window runs in real time and the drive cannot be stalled, so there is no back-pressure at all. Every rising edge of the raw input is handled in the cycle it is detected. The parameter PHASES sets how many sample clocks make up one window half-cycle (default 8). The snap phase is PHASES/2.

Top module: `data_window_gen`

## Requirements
- R1: While rst_n is low, rd_window and rd_data are both 0, whatever rd_raw and sync_en do.
- R2: While sync_en is low, rd_window stays 0 and rd_data stays 0, and rd_raw transitions have no effect. One clock after sync_en is sampled low, both outputs are 0.
- R3: After sync_en goes high with no pulse, rd_window first changes on the 8th rising clock edge at which sync_en is sampled high. This shows that the phase ring restarts from its cleared phase.
- R4: With no pulse arriving, rd_window toggles exactly once every 8 sample clocks and holds its level in between.
- R5: Each low-to-high transition of rd_raw, as sampled on a clock edge, gives exactly one rd_data pulse one clock wide. It is visible after the third rising edge that follows the first sample of the high level. A level held high for many clocks still gives only one pulse.
- R6: After each rd_data pulse, if no further pulse arrives, the next rd_window toggle comes exactly 4 clocks after the cycle in which rd_data is high. Toggles then resume every 8 clocks.
- R7: rd_window does not change on the edge that raises rd_data, nor on the three edges after it. Each data pulse therefore sits at the centre of a window half-cycle.
- R8: A pulse whose phase snap falls on the edge where a toggle was due suppresses that toggle. A second pulse that arrives before the pending toggle re-snaps the phase and pushes the toggle back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, PHASES times the half-window rate |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_raw | input | 1 | Raw read pulse from the drive, asynchronous |
| sync_en | input | 1 | Controller enable; low holds the generator cleared |
| rd_data | output | 1 | One-clock data pulse aligned to the window centre |
| rd_window | output | 1 | Read data window |

## Verification
A stimulus table places a single pulse at several offsets from the start of the free-running window. The offsets cover a pulse early in a half-window, a pulse just after a natural toggle, and pulses whose snap lands exactly on a due toggle. These cases separate correct centring from an off-by-one snap phase, and show whether toggle suppression is present. One table row sends two pulses four clocks apart, which shows whether a pending toggle is re-timed. Directed runs cover the free-running window after enable, pulses while disabled, reset with active inputs, and a long high level on the raw line, which must not produce repeated data pulses.

// File: rtl/dwg_pkg.sv
package dwg_pkg;
  localparam int unsigned DWG_DEF_PHASES      = 8;
  localparam int unsigned DWG_DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/dwg_pulse_sync.sv
module dwg_pulse_sync #(
  parameter int unsigned STAGES = dwg_pkg::DWG_DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic evt_o
);
  localparam int unsigned TOP = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], raw_i};
      last_q  <= chain_q[TOP];
    end
  end

  // Rising edge of the synchronized level: exactly one cycle per transition
  assign evt_o = chain_q[TOP] & ~last_q;

  assert_single_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> !evt_o);
endmodule

// File: rtl/dwg_phase_ring.sv
module dwg_phase_ring #(
  parameter int unsigned PHASES = dwg_pkg::DWG_DEF_PHASES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic snap_i,
  output logic wrap_o
);
  localparam int unsigned SNAP = PHASES / 2;
  localparam int unsigned LAST = PHASES - 1;

  logic [PHASES-1:0] tok_q;
  logic [PHASES-1:0] tok_d;

  for (genvar g = 0; g < PHASES; g++) begin : g_cell
    localparam int unsigned PREV = (g + PHASES - 1) % PHASES;
    always_comb begin
      if (!run_i)      tok_d[g] = (g == 0);
      else if (snap_i) tok_d[g] = (g == SNAP);
      else             tok_d[g] = tok_q[PREV];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tok_q <= PHASES'(1);
    else        tok_q <= tok_d;
  end

  // A wrap is due when the token leaves the last phase; a snap overrides it
  assign wrap_o = run_i & tok_q[LAST] & ~snap_i;

  assert_token_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tok_q) == 1);
  assert_snap_centre_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && snap_i) |=> tok_q[SNAP]);
  assert_idle_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> tok_q[0]);
endmodule

// File: rtl/dwg_window_tff.sv
module dwg_window_tff (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tgl_i,
  output logic win_o
);
  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) win_o <= 1'b0;
    else if (tgl_i)       win_o <= ~win_o;
  end

  assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !win_o);
endmodule

// File: rtl/dwg_data_align.sv
module dwg_data_align (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic evt_i,
  output logic data_o
);
  // One register: the pulse appears in the same cycle the ring sits at the snap phase
  always_ff @(posedge clk) begin
    if (!rst_n) data_o <= 1'b0;
    else        data_o <= evt_i & run_i;
  end

  assert_data_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !data_o);
endmodule

// File: rtl/data_window_gen.sv
module data_window_gen #(
  parameter int unsigned PHASES      = dwg_pkg::DWG_DEF_PHASES,
  parameter int unsigned SYNC_STAGES = dwg_pkg::DWG_DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_raw,
  input  logic sync_en,
  output logic rd_data,
  output logic rd_window
);
  logic evt;
  logic wrap;

  dwg_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(rd_raw), .evt_o(evt)
  );

  dwg_phase_ring #(.PHASES(PHASES)) u_ring (
    .clk(clk), .rst_n(rst_n), .run_i(sync_en), .snap_i(evt), .wrap_o(wrap)
  );

  dwg_window_tff u_tff (
    .clk(clk), .rst_n(rst_n), .run_i(sync_en), .tgl_i(wrap), .win_o(rd_window)
  );

  dwg_data_align u_align (
    .clk(clk), .rst_n(rst_n), .run_i(sync_en), .evt_i(evt), .data_o(rd_data)
  );

  assert_window_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data |-> $stable(rd_window));
  assert_window_after_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data |=> $stable(rd_window));
  assert_disabled_outputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en |=> (!rd_window && !rd_data));
  assert_reset_outputs_R1: assert property (@(posedge clk)
    !rst_n |=> (!rd_window && !rd_data));
endmodule

// File: tb/data_window_gen_tb_top.sv
module data_window_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {first pulse slot, second pulse slot (0 = none), expected toggle A, expected toggle B}
  localparam int VEC [NV][4] = '{
    '{0, 0, 7, 15}, '{2, 0, 9, 17}, '{5, 0, 12, 20}, '{6, 0, 13, 21},
    '{13, 0, 20, 28}, '{14, 0, 21, 29}, '{20, 0, 27, 35}, '{2, 6, 13, 21}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_raw = 1'b0;
  logic sync_en = 1'b0;
  logic rd_data;
  logic rd_window;
  int   n_checks = 0;
  int   n_errors = 0;
  logic tg [0:63];
  logic dt [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  data_window_gen dut_i (
    .clk(clk), .rst_n(rst_n), .rd_raw(rd_raw), .sync_en(sync_en),
    .rd_data(rd_data), .rd_window(rd_window)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  // Clears, raises sync at slot 0, launches pulses, records slots 1..len
  task automatic run_slots(input int w1, input int w2, input int hold, input int len);
    logic prev;
    sync_en = 1'b0;
    rd_raw  = 1'b0;
    repeat (3) @(negedge clk);
    prev = rd_window;
    sync_en = 1'b1;
    if (w1 == 0) rd_raw = 1'b1;
    for (int i = 1; i <= len; i++) begin
      @(negedge clk);
      dt[i] = rd_data;
      tg[i] = (rd_window != prev);
      prev  = rd_window;
      if (w1 >= 0 && (i == w1 || (w2 != 0 && i == w2))) rd_raw = 1'b1;
      if (w1 >= 0 && (i == w1 + hold || (w2 != 0 && i == w2 + hold))) rd_raw = 1'b0;
    end
    rd_raw = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int cnt_d;
    int cnt_w;
    int bad;
    int first;

    // R1: reset with active inputs
    sync_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      rd_raw = ~rd_raw;
      check(rd_window == 1'b0 && rd_data == 1'b0, "R1", "outputs in reset",
            {rd_window, rd_data}, 0);
    end
    sync_en = 1'b0;
    rd_raw  = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R2: pulses while disabled
    cnt_d = 0;
    cnt_w = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (rd_data) cnt_d++;
      if (rd_window) cnt_w++;
      rd_raw = ((i % 6) < 3);
    end
    rd_raw = 1'b0;
    check(cnt_d == 0, "R2", "rd_data pulses while disabled", cnt_d, 0);
    check(cnt_w == 0, "R2", "window high cycles while disabled", cnt_w, 0);

    // R3, R4: free run after enable, no pulses
    run_slots(-1, 0, 2, 41);
    first = 0;
    bad = 0;
    for (int i = 41; i >= 1; i--) if (tg[i]) first = i;
    for (int i = 1; i <= 41; i++) if (tg[i] != (i % 8 == 0)) bad++;
    check(first == 8, "R3", "first window toggle slot", first, 8);
    check(bad == 0, "R4", "free-run toggle slots mismatched", bad, 0);

    // R5: long high level gives one pulse
    run_slots(2, 0, 18, 26);
    cnt_d = 0;
    bad = 0;
    for (int i = 1; i <= 26; i++) begin
      if (dt[i]) cnt_d++;
      if (dt[i] != (i == 5)) bad++;
    end
    check(cnt_d == 1, "R5", "pulses from long high level", cnt_d, 1);
    check(bad == 0, "R5", "long level pulse slot mismatches", bad, 0);

    // Table walk: R5 data slot, R6/R8 toggle slots, R7 window hold
    for (int v = 0; v < NV; v++) begin
      int w1;
      int w2;
      int ta;
      int tb;
      int len;
      int d;
      string rq;
      w1  = VEC[v][0];
      w2  = VEC[v][1];
      ta  = VEC[v][2];
      tb  = VEC[v][3];
      len = tb + 3;
      run_slots(w1, w2, 2, len);
      bad = 0;
      for (int i = 1; i <= len; i++)
        if (dt[i] != ((i == w1 + 3) || (w2 != 0 && i == w2 + 3))) bad++;
      check(bad == 0, "R5", $sformatf("vector %0d data slot mismatches", v), bad, 0);
      bad = 0;
      for (int i = 1; i <= len; i++)
        if (tg[i] != (((i % 8 == 0) && (i <= w1 + 2)) || i == ta || i == tb)) bad++;
      rq = (w2 != 0 || ((w1 + 2) % 8 == 7)) ? "R8" : "R6";
      check(bad == 0, rq, $sformatf("vector %0d toggle slot mismatches", v), bad, 0);
      d = ((w2 != 0) ? w2 : w1) + 3;
      cnt_w = 0;
      for (int i = d; i <= d + 3; i++) if (tg[i]) cnt_w++;
      check(cnt_w == 0, "R7", $sformatf("vector %0d window changes near pulse", v), cnt_w, 0);
    end

    finish_run();
  end
endmodule